// File: doc/BRIEF.md
# SATA Port COMRESET Sequencer

This block runs a hard reset on one SATA port without software involvement. A start pulse loads a deadline counter, which counts millisecond ticks. The block asks the command engine to stop and waits until it reports idle, but for no more than a bounded time. It then drives the port control detect field to the COMRESET code for a minimum hold time and releases it. After that it waits for the PHY detect state to show a debounced link, retrying a limited number of times.

While the sequence runs, the block keeps the port-side status copies in line with the reset:
- The shadow task-file status is forced while COMRESET is held.
- A COMINIT from the device sets the busy bit.
- The error register is cleared once the link is back.
- The first device-to-host Register FIS after the reset loads the status, error and signature registers.

The run ends with exactly one of three results: done, offline or timeout. Done means the busy bit cleared before the deadline.

Top module: `sata_comreset_seq`

## Requirements
- R1: After an accepted start, `engine_stop_o` is high and `comreset_o` stays low. This lasts until `cmd_running_i` is low, or until `STOP_WAIT_MS` (default 500) ms ticks have passed in that phase, whichever comes first. COMRESET is then asserted regardless.
- R2: When COMRESET begins, `sctl_o` reads {IPM=4'h3 in bits 11:8, speed nibble in bits 7:4, DET=4'h1 in bits 3:0}. The speed nibble is captured from `spd_lim_i` at start and does not change for the rest of the run.
- R3: From the cycle after DET becomes 4'h1 and while it stays there, `tfd_sts_o` reads 8'h7F and `ssts_det_o` reads 4'h0, whatever `phy_det_i` shows. Outside that window, `ssts_det_o` follows `phy_det_i` one cycle later.
- R4: DET stays at 4'h1 for exactly `HOLD_MS`+1 ms ticks, which is more than `HOLD_MS` whole milliseconds. It then returns to 4'h0 with IPM kept at 4'h3, and `comreset_o` drops at the same time.
- R5: The link counts as up once bit 0 of `phy_det_i` has been 1 for `DEBOUNCE_CYC` consecutive cycles. Each attempt lasts `RESUME_MS` ticks. After `RESUME_TRIES` (default 5) failed attempts, `offline_o` is set, `RESUME_MS`*`RESUME_TRIES` ticks after DET was released. A link that comes up in a later attempt lets the run go on normally.
- R6: After DET returns to 4'h0 and while the run is active, a `cominit_i` pulse sets bit 7 (BSY) of `tfd_sts_o`.
- R7: `serr_o` accumulates `serr_set_i` by OR. It is cleared to zero as soon as the link is detected up.
- R8: The first FIS (`fis_valid_i`) after DET is released loads `tfd_sts_o` and `tfd_err_o`. It also loads `sig_o` = {LBA high, LBA mid, LBA low, sector count}, with the sector count in bits 7:0.
- R9: Any later FIS in the same run, and any FIS outside the post-release window, leaves `sig_o`, `tfd_sts_o` and `tfd_err_o` unchanged.
- R10: Once a FIS has been captured, `done_o` is set when BSY (status bit 7) is 0. If BSY has not cleared by the time the deadline counter reaches 0, `timeout_o` is set instead.
- R11: Each accepted start reloads the deadline counter from `deadline_ms_i`. The counter drops by one on every ms tick from then on, so a timeout lands `deadline_ms_i` ticks after the start.
- R12: A `start_i` pulse during a run is ignored. The run carries on without returning to the engine-stop or COMRESET phases.
- R13: `busy_o` is high during a run. `done_o`, `offline_o` and `timeout_o` are mutually exclusive, stay set until the next accepted start, and are cleared by that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a port hard reset |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| deadline_ms_i | input | DL_W | Deadline in ms, loaded on start |
| spd_lim_i | input | 4 | Speed-limit nibble for the control word |
| cmd_running_i | input | 1 | Command engine still running |
| phy_det_i | input | 4 | Raw PHY detect state |
| cominit_i | input | 1 | COMINIT received from device |
| serr_set_i | input | 32 | Error bits raised by the link layer |
| fis_valid_i | input | 1 | D2H Register FIS received |
| fis_status_i | input | 8 | FIS status byte |
| fis_error_i | input | 8 | FIS error byte |
| fis_sect_cnt_i | input | 8 | FIS sector count |
| fis_lba_lo_i | input | 8 | FIS LBA low |
| fis_lba_mid_i | input | 8 | FIS LBA mid |
| fis_lba_hi_i | input | 8 | FIS LBA high |
| engine_stop_o | output | 1 | Command engine must stop |
| comreset_o | output | 1 | COMRESET request to OOB logic |
| sctl_o | output | 12 | Control word {IPM, SPD, DET} |
| tfd_sts_o | output | 8 | Shadow task-file status |
| tfd_err_o | output | 8 | Shadow task-file error |
| ssts_det_o | output | 4 | Reported detect state |
| sig_o | output | 32 | Device signature |
| serr_o | output | 32 | Accumulated link errors |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Reset completed with BSY clear |
| offline_o | output | 1 | Link did not come up |
| timeout_o | output | 1 | Deadline passed with BSY set |

## Verification
The bench targets these corner cases:
- **Engine that never idles.** The bench holds the command engine running for the full stop window and expects COMRESET close to 500 ticks later. A design with no bound would hang here.
- **PHY reporting a link during COMRESET.** The bench checks that the detect field still reads zero while COMRESET is held. A design that does not force it would pass the raw PHY state through.
- **Link detect bit that toggles faster than the debounce window.** This must end offline after exactly five attempts. A design without the filter would declare the link up.
- **Two FISes in one run.** The second must not overwrite the signature.
- **FIS that leaves BSY set.** The timeout must land on the loaded deadline.
- **Start pulse in mid-run.** It must not restart the sequence.

// File: rtl/sata_crs_pkg.sv
package sata_crs_pkg;
  typedef enum logic [2:0] {
    CRS_IDLE,
    CRS_STOP,
    CRS_HOLD,
    CRS_RESUME,
    CRS_CLRERR,
    CRS_WAITRDY
  } crs_state_e;

  localparam logic [3:0] IPM_NO_LPM   = 4'h3;
  localparam logic [3:0] DET_COMRESET = 4'h1;
  localparam logic [3:0] DET_RELEASE  = 4'h0;
  localparam logic [7:0] STS_IN_RESET = 8'h7F;
  localparam int         STS_BSY_BIT  = 7;
endpackage

// File: rtl/crs_ms_timer.sv
module crs_ms_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
    end else if (tick_i && (cnt_o != {W{1'b1}})) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/crs_debounce.sv
module crs_debounce #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic level_i,
  output logic stable_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i || !level_i) begin
      run_q <= '0;
    end else if (run_q != CW'(CYC)) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign stable_o = (run_q == CW'(CYC));

  AST_DEB_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $rose(stable_o) |-> $past(level_i)); // R5
endmodule

// File: rtl/crs_taskfile.sv
module crs_taskfile
  import sata_crs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        force_i,
  input  logic        arm_i,
  input  logic        seen_clr_i,
  input  logic        cominit_i,
  input  logic        fis_valid_i,
  input  logic [7:0]  fis_status_i,
  input  logic [7:0]  fis_error_i,
  input  logic [7:0]  fis_sect_cnt_i,
  input  logic [7:0]  fis_lba_lo_i,
  input  logic [7:0]  fis_lba_mid_i,
  input  logic [7:0]  fis_lba_hi_i,
  output logic [7:0]  sts_o,
  output logic [7:0]  err_o,
  output logic [31:0] sig_o,
  output logic        seen_o
);
  logic take;
  assign take = arm_i && fis_valid_i && !seen_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_o  <= STS_IN_RESET;
      err_o  <= '0;
      sig_o  <= '0;
      seen_o <= 1'b0;
    end else begin
      if (seen_clr_i) begin
        seen_o <= 1'b0;
      end else if (take) begin
        seen_o <= 1'b1;
      end
      if (force_i) begin
        sts_o <= STS_IN_RESET;
      end else if (take) begin
        sts_o <= fis_status_i;
      end else if (arm_i && cominit_i) begin
        sts_o[STS_BSY_BIT] <= 1'b1;
      end
      if (take) begin
        err_o <= fis_error_i;
        sig_o <= {fis_lba_hi_i, fis_lba_mid_i, fis_lba_lo_i, fis_sect_cnt_i};
      end
    end
  end

  AST_SIG_HELD_AFTER_FIRST: assert property (@(posedge clk) disable iff (rst)
    (seen_o && !seen_clr_i) |=> $stable(sig_o)); // R9
  AST_COMINIT_SETS_BSY: assert property (@(posedge clk) disable iff (rst)
    (arm_i && cominit_i && !force_i && !fis_valid_i) |=> sts_o[STS_BSY_BIT]); // R6
endmodule

// File: rtl/sata_comreset_seq.sv
module sata_comreset_seq
  import sata_crs_pkg::*;
#(
  parameter int DL_W         = 16,
  parameter int STOP_WAIT_MS = 500,
  parameter int HOLD_MS      = 1,
  parameter int RESUME_MS    = 10,
  parameter int RESUME_TRIES = 5,
  parameter int DEBOUNCE_CYC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            ms_tick_i,
  input  logic [DL_W-1:0] deadline_ms_i,
  input  logic [3:0]      spd_lim_i,
  input  logic            cmd_running_i,
  input  logic [3:0]      phy_det_i,
  input  logic            cominit_i,
  input  logic [31:0]     serr_set_i,
  input  logic            fis_valid_i,
  input  logic [7:0]      fis_status_i,
  input  logic [7:0]      fis_error_i,
  input  logic [7:0]      fis_sect_cnt_i,
  input  logic [7:0]      fis_lba_lo_i,
  input  logic [7:0]      fis_lba_mid_i,
  input  logic [7:0]      fis_lba_hi_i,
  output logic            engine_stop_o,
  output logic            comreset_o,
  output logic [11:0]     sctl_o,
  output logic [7:0]      tfd_sts_o,
  output logic [7:0]      tfd_err_o,
  output logic [3:0]      ssts_det_o,
  output logic [31:0]     sig_o,
  output logic [31:0]     serr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            offline_o,
  output logic            timeout_o
);
  localparam int MAX_A  = (STOP_WAIT_MS > RESUME_MS) ? STOP_WAIT_MS : RESUME_MS;
  localparam int PH_MAX = (MAX_A > HOLD_MS + 1) ? MAX_A : HOLD_MS + 1;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int TRY_W  = $clog2(RESUME_TRIES + 1);

  crs_state_e       state_q, state_n;
  logic [PH_W-1:0]  ph_ms;
  logic             ph_clr;
  logic [TRY_W-1:0] try_q;
  logic             try_inc;
  logic [DL_W-1:0]  dl_q;
  logic             link_up;
  logic             fis_seen;
  logic             fin_done, fin_off, fin_to;
  logic             accept;
  logic             tf_arm;

  assign accept = (state_q == CRS_IDLE) && start_i;
  assign tf_arm = (state_q == CRS_RESUME) || (state_q == CRS_CLRERR) ||
                  (state_q == CRS_WAITRDY);

  crs_ms_timer #(.W(PH_W)) phase_tmr_i (
    .clk   (clk),
    .rst   (rst),
    .clr_i (ph_clr),
    .tick_i(ms_tick_i),
    .cnt_o (ph_ms)
  );

  crs_debounce #(.CYC(DEBOUNCE_CYC)) link_deb_i (
    .clk     (clk),
    .rst     (rst),
    .en_i    ((state_q == CRS_RESUME) && !try_inc),
    .level_i (phy_det_i[0]),
    .stable_o(link_up)
  );

  crs_taskfile tf_i (
    .clk           (clk),
    .rst           (rst),
    .force_i       (sctl_o[3:0] == DET_COMRESET),
    .arm_i         (tf_arm),
    .seen_clr_i    (accept),
    .cominit_i     (cominit_i),
    .fis_valid_i   (fis_valid_i),
    .fis_status_i  (fis_status_i),
    .fis_error_i   (fis_error_i),
    .fis_sect_cnt_i(fis_sect_cnt_i),
    .fis_lba_lo_i  (fis_lba_lo_i),
    .fis_lba_mid_i (fis_lba_mid_i),
    .fis_lba_hi_i  (fis_lba_hi_i),
    .sts_o         (tfd_sts_o),
    .err_o         (tfd_err_o),
    .sig_o         (sig_o),
    .seen_o        (fis_seen)
  );

  always_comb begin
    state_n  = state_q;
    ph_clr   = 1'b0;
    try_inc  = 1'b0;
    fin_done = 1'b0;
    fin_off  = 1'b0;
    fin_to   = 1'b0;
    unique case (state_q)
      CRS_IDLE: if (start_i) state_n = CRS_STOP;
      CRS_STOP: if (!cmd_running_i || (ph_ms >= PH_W'(STOP_WAIT_MS))) state_n = CRS_HOLD;
      CRS_HOLD: if (ph_ms >= PH_W'(HOLD_MS + 1)) state_n = CRS_RESUME;
      CRS_RESUME: begin
        if (link_up) begin
          state_n = CRS_CLRERR;
        end else if (ph_ms >= PH_W'(RESUME_MS)) begin
          if (try_q == TRY_W'(RESUME_TRIES - 1)) begin
            state_n = CRS_IDLE;
            fin_off = 1'b1;
          end else begin
            try_inc = 1'b1;
            ph_clr  = 1'b1;
          end
        end
      end
      CRS_CLRERR: state_n = CRS_WAITRDY;
      CRS_WAITRDY: begin
        if (fis_seen && !tfd_sts_o[STS_BSY_BIT]) begin
          state_n  = CRS_IDLE;
          fin_done = 1'b1;
        end else if (dl_q == '0) begin
          state_n = CRS_IDLE;
          fin_to  = 1'b1;
        end
      end
      default: state_n = CRS_IDLE;
    endcase
    if (state_n != state_q) ph_clr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= CRS_IDLE;
      try_q      <= '0;
      dl_q       <= '0;
      sctl_o     <= '0;
      comreset_o <= 1'b0;
      ssts_det_o <= '0;
      serr_o     <= '0;
      done_o     <= 1'b0;
      offline_o  <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      state_q <= state_n;
      // deadline: reload on start, count down on ticks while running
      if (accept) begin
        dl_q <= deadline_ms_i;
      end else if ((state_q != CRS_IDLE) && ms_tick_i && (dl_q != '0)) begin
        dl_q <= dl_q - 1'b1;
      end
      if (accept) begin
        try_q <= '0;
      end else if (try_inc) begin
        try_q <= try_q + 1'b1;
      end
      // control word
      if (accept) begin
        sctl_o[7:4] <= spd_lim_i;
      end
      if (state_q == CRS_STOP && state_n == CRS_HOLD) begin
        sctl_o[11:8] <= IPM_NO_LPM;
        sctl_o[3:0]  <= DET_COMRESET;
        comreset_o   <= 1'b1;
      end else if (state_q == CRS_HOLD && state_n == CRS_RESUME) begin
        sctl_o[3:0] <= DET_RELEASE;
        comreset_o  <= 1'b0;
      end
      ssts_det_o <= (sctl_o[3:0] == DET_COMRESET) ? 4'h0 : phy_det_i;
      if (state_q == CRS_RESUME && link_up) begin
        serr_o <= '0;
      end else begin
        serr_o <= serr_o | serr_set_i;
      end
      if (accept) begin
        done_o    <= 1'b0;
        offline_o <= 1'b0;
        timeout_o <= 1'b0;
      end else begin
        if (fin_done) done_o    <= 1'b1;
        if (fin_off)  offline_o <= 1'b1;
        if (fin_to)   timeout_o <= 1'b1;
      end
    end
  end

  assign busy_o        = (state_q != CRS_IDLE);
  assign engine_stop_o = (state_q == CRS_STOP);

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, offline_o, timeout_o})); // R13
  AST_SPD_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(sctl_o[7:4])); // R2
  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (rst)
    try_q < TRY_W'(RESUME_TRIES)); // R5
  AST_STOP_BEFORE_COMRESET: assert property (@(posedge clk) disable iff (rst)
    $rose(comreset_o) |-> $past(state_q == CRS_STOP)); // R1
  AST_FORCED_STATUS: assert property (@(posedge clk) disable iff (rst)
    (sctl_o[3:0] == DET_COMRESET) |=> (tfd_sts_o == STS_IN_RESET && ssts_det_o == 4'h0)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && state_q != CRS_STOP) |=> !engine_stop_o); // R12
endmodule

// File: tb/sata_comreset_seq_tb.sv
module sata_comreset_seq_tb_top;
  localparam int HOLD   = 1;
  localparam int RES_MS = 10;
  localparam int TRIES  = 5;
  localparam int DEB    = 8;
  localparam int STOPW  = 500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, ms_tick = 0, cmd_running = 0, cominit = 0, fis_valid = 0;
  logic [15:0] deadline = 0;
  logic [3:0]  spd = 0, phy_det = 0;
  logic [31:0] serr_set = 0;
  logic [7:0]  f_sts = 0, f_err = 0, f_sc = 0, f_lo = 0, f_mid = 0, f_hi = 0;
  logic        engine_stop, comreset, busy, done, offline, timeout;
  logic [11:0] sctl;
  logic [7:0]  tsts, terr;
  logic [3:0]  ssts;
  logic [31:0] sig, serr;

  int tests = 0, fails = 0, tick_total = 0, div = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    div <= (div == 9) ? 0 : div + 1;
    ms_tick <= (div == 9);
    if (ms_tick) tick_total <= tick_total + 1;
  end

  sata_comreset_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start), .ms_tick_i(ms_tick),
    .deadline_ms_i(deadline), .spd_lim_i(spd), .cmd_running_i(cmd_running),
    .phy_det_i(phy_det), .cominit_i(cominit), .serr_set_i(serr_set),
    .fis_valid_i(fis_valid), .fis_status_i(f_sts), .fis_error_i(f_err),
    .fis_sect_cnt_i(f_sc), .fis_lba_lo_i(f_lo), .fis_lba_mid_i(f_mid),
    .fis_lba_hi_i(f_hi), .engine_stop_o(engine_stop), .comreset_o(comreset),
    .sctl_o(sctl), .tfd_sts_o(tsts), .tfd_err_o(terr), .ssts_det_o(ssts),
    .sig_o(sig), .serr_o(serr), .busy_o(busy), .done_o(done),
    .offline_o(offline), .timeout_o(timeout)
  );

  function automatic logic [11:0] exp_sctl(input logic [3:0] s, input logic [3:0] d);
    return {4'h3, s, d};
  endfunction

  function automatic logic [31:0] exp_sig(input logic [7:0] c, l, m, h);
    return {h, m, l, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic send_fis(input logic [7:0] s, e, c, l, m, h);
    @(negedge clk);
    fis_valid = 1; f_sts = s; f_err = e; f_sc = c; f_lo = l; f_mid = m; f_hi = h;
    @(negedge clk) fis_valid = 0;
  endtask

  task automatic wait_comreset(input logic lvl, input int bound);
    for (int k = 0; k < bound && comreset !== lvl; k++) @(negedge clk);
  endtask

  task automatic wait_end(input int bound);
    for (int k = 0; k < bound && busy; k++) @(negedge clk);
  endtask

  task automatic run_good(input int hold_cyc, input bit poke);
    logic [31:0] r, se;
    logic [7:0] s, e, c, l, m, h;
    int t0;
    r = $urandom; spd = r[3:0];
    r = $urandom; s = r[7:0] & 8'h7F; e = r[15:8]; c = r[23:16]; l = r[31:24];
    r = $urandom; m = r[7:0]; h = r[15:8];
    se = $urandom | 32'h1;
    deadline = 16'd2000; cmd_running = 1; phy_det = 4'h3;
    pulse_start();
    chk("R13 result cleared by start", {29'd0, done, offline, timeout}, 0);
    @(negedge clk) serr_set = se;
    @(negedge clk) serr_set = 0;
    repeat (hold_cyc) @(negedge clk);
    chk("R1 engine stop while running", engine_stop, 1);
    chk("R1 no comreset while running", comreset, 0);
    cmd_running = 0;
    wait_comreset(1, 50);
    chk("R2 control word at comreset", sctl, exp_sctl(spd, 4'h1));
    repeat (2) @(negedge clk);
    chk("R3 status forced", tsts, 8'h7F);
    chk("R3 detect forced to zero", ssts, 0);
    chk("R7 errors accumulate", serr, se);
    t0 = tick_total;
    wait_comreset(0, 200);
    phy_det = 4'h0;
    chk_rng("R4 hold ticks", tick_total - t0, HOLD + 1, HOLD + 1);
    chk("R4 DET released", sctl, exp_sctl(spd, 4'h0));
    @(negedge clk) cominit = 1;
    @(negedge clk) cominit = 0;
    chk("R6 cominit sets BSY", tsts, 8'hFF);
    if (poke) begin
      pulse_start();
      chk("R12 no engine stop on restart", engine_stop, 0);
      chk("R12 no comreset on restart", comreset, 0);
      chk("R12 still busy", busy, 1);
    end
    phy_det = 4'h3;
    repeat (DEB + 4) @(negedge clk);
    chk("R7 errors cleared at link up", serr, 0);
    chk("R3 detect follows phy", ssts, 4'h3);
    send_fis(s, e, c, l, m, h);
    chk("R8 status captured", tsts, s);
    chk("R8 error captured", terr, e);
    chk("R8 signature packed", sig, exp_sig(c, l, m, h));
    send_fis(8'h50, ~e, ~c, ~l, ~m, ~h);
    chk("R9 second FIS ignored", sig, exp_sig(c, l, m, h));
    chk("R9 status kept", tsts, s);
    wait_end(100);
    chk("R10 done", {done, offline, timeout, busy}, 4'b1000);
  endtask

  task automatic run_offline(input int mode);
    int t0;
    deadline = 16'd3000; cmd_running = 0; phy_det = 4'h0;
    pulse_start();
    wait_comreset(1, 50);
    wait_comreset(0, 200);
    t0 = tick_total;
    for (int k = 0; k < 2000 && busy; k++) begin
      @(negedge clk);
      if (mode == 1) phy_det = ((k / 4) % 2 == 0) ? 4'h1 : 4'h0;
      if (mode == 2 && (tick_total - t0) >= 25) phy_det = 4'h3;
      if (mode == 2 && (tick_total - t0) == 28 && !fis_valid && !done) begin
        fis_valid = 1; f_sts = 8'h40; f_err = 8'h01; f_sc = 1; f_lo = 1; f_mid = 0; f_hi = 0;
        @(negedge clk) fis_valid = 0;
      end
    end
    if (mode == 2) begin
      chk("R5 later attempt succeeds", {done, offline}, 2'b10);
    end else begin
      chk("R5 offline after tries", {done, offline, timeout}, 3'b010);
      chk_rng("R5 offline time", tick_total - t0, RES_MS * TRIES - 1, RES_MS * TRIES + 1);
    end
    phy_det = 4'h0;
  endtask

  task automatic run_timeout(input int d);
    int t0;
    deadline = 16'(d); cmd_running = 0; phy_det = 4'h3;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    t0 = tick_total;
    wait_comreset(1, 50);
    wait_comreset(0, 200);
    repeat (DEB + 4) @(negedge clk);
    send_fis(8'hD0, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    wait_end(4000);
    chk("R10 timeout with BSY set", {done, offline, timeout}, 3'b001);
    chk_rng("R11 deadline reload", tick_total - t0, d - 1, d + 1);
    phy_det = 4'h0;
  endtask

  initial begin
    int t0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R13 reset idle", {busy, done, offline, timeout, engine_stop, comreset}, 0);
    chk("R2 reset control word", sctl, 0);
    chk("R8 reset signature", sig, 0);
    chk("R7 reset error reg", serr, 0);
    for (int i = 0; i < 3; i++) run_good(3 + i * 7, i == 1);
    run_offline(0);
    run_offline(1);
    run_offline(2);
    run_timeout(9);
    run_timeout(17);
    // engine never stops: bounded stop wait
    cmd_running = 1; phy_det = 4'h0; deadline = 16'd1000;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    t0 = tick_total;
    wait_comreset(1, 6000);
    chk_rng("R1 stop wait bound", tick_total - t0, STOPW - 1, STOPW + 1);
    cmd_running = 0;
    wait_comreset(0, 200);
    phy_det = 4'h3;
    repeat (DEB + 4) @(negedge clk);
    send_fis(8'h50, 0, 1, 1, 0, 0);
    wait_end(100);
    chk("R10 done after stop bound", done, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule